// File: doc/BRIEF.md
# Hardware Barrier Synchronization Unit

This block holds a group of processors at a synchronization point until a set number of them have reached it, then lets them all continue. Each processor raises its arrival request line and keeps it high. The unit takes in at most one arrival per clock and keeps a shared occupancy count. Once the count reaches the participant limit, no more arrivals are accepted. The waiting processors are then let go one per clock. Each one gets a single-cycle release pulse and is expected to lower its request after that pulse.

Two internal gates decide which phase is active. The entry gate accepts arrivals. The exit gate hands out releases. Exactly one of the two is open at any time. The entry gate only opens again after the last waiting processor has been released. Because of this, a fast processor that comes back for the next episode cannot be counted into the episode that is still draining. It is simply held until the unit is idle again. The participant limit is an input, but it is only taken while the unit is idle, and out-of-range values are pulled into range.

Top module: `barrier_sync`

## Requirements
- R1: During and directly after reset the count is 0, the entry gate is open (`arr_open`=1), the exit gate is closed (`dep_open`=0) and no release pulse is driven.
- R2: While the entry gate is open, in each cycle the lowest-numbered processor that requests and has not yet been counted is accepted. The count rises by exactly 1 per accepted arrival. A request from a processor already counted has no effect.
- R3: After an arrival that leaves the count below the limit, the entry gate stays open. The arrival that brings the count to the limit closes the entry gate and opens the exit gate on the same clock edge. The two gates are never open together.
- R4: While the exit gate is open, in each cycle the lowest-numbered counted processor is released. Its bit of `go` is high for exactly one cycle, and the count falls by 1. At most one `go` bit is high at a time.
- R5: The release that brings the count to 0 closes the exit gate and reopens the entry gate on the same edge.
- R6: No processor receives a release pulse before the count has reached the limit.
- R7: Requests made while the exit gate is open leave the count unchanged. They are accepted, lowest number first, once the entry gate reopens.
- R8: The limit is taken from `part_n` only while the unit is idle (entry gate open and count 0). Changes to `part_n` during an episode have no effect on that episode.
- R9: A `part_n` of 0 acts as 1, and a `part_n` above the processor count acts as the processor count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| part_n | input | CW = $clog2(NPROC+1) | Participant limit for the next episode |
| arr_req | input | NPROC | Per-processor arrival request, held until released |
| go | output | NPROC | Per-processor single-cycle release pulse |
| arr_open | output | 1 | Entry gate open |
| dep_open | output | 1 | Exit gate open |
| cnt | output | CW | Processors currently counted in the barrier |

## Verification
The bench uses simultaneous requests to test serialization. A design with a broken priority chain would count two arrivals in one cycle, or would release processors in the wrong order. Processors that come back during the drain must stay uncounted: a design that reopened the entry gate too early would let them into the old episode and push the count past the limit. The bench also changes `part_n` in the middle of an episode and drives out-of-range values. A design that did not latch or clamp the limit would release too early, or would never release at all.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    // Which of the two gates currently admits traffic.
    typedef enum logic {
        GATE_ENTRY = 1'b0,
        GATE_EXIT  = 1'b1
    } gate_e;

    // Decoded view of the gate register.
    typedef struct packed {
        logic entry_open;
        logic exit_open;
    } gate_view_t;

    // Pull a requested participant limit into the legal range 1..max_n.
    function automatic int clamp_part(input int req_n, input int max_n);
        if (req_n < 1)
            return 1;
        if (req_n > max_n)
            return max_n;
        return req_n;
    endfunction

    function automatic gate_view_t view_of(input gate_e g);
        gate_view_t v;
        v.entry_open = (g == GATE_ENTRY);
        v.exit_open  = (g == GATE_EXIT);
        return v;
    endfunction

endpackage

// File: rtl/barrier_pick.sv
// Lowest-index-first single grant, built as a prefix chain.
module barrier_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] cand,
    output logic [W-1:0] grant,
    output logic         any
);
    logic [W:0] seen;

    assign seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_chain
            assign grant[gi]  = cand[gi] & ~seen[gi];
            assign seen[gi+1] = seen[gi] | cand[gi];
        end
    endgenerate

    assign any = seen[W];
endmodule

// File: rtl/barrier_slots.sv
// One "counted" flag per processor: set on admission, cleared on release.
module barrier_slots #(
    parameter int NPROC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPROC-1:0] set_v,
    input  logic [NPROC-1:0] clr_v,
    output logic [NPROC-1:0] held
);
    genvar gi;
    generate
        for (gi = 0; gi < NPROC; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    held[gi] <= 1'b0;
                else if (set_v[gi])
                    held[gi] <= 1'b1;
                else if (clr_v[gi])
                    held[gi] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/barrier_gate.sv
// Shared count, latched limit and the two-phase gate register.
module barrier_gate
    import barrier_pkg::*;
#(
    parameter int NPROC = 8,
    parameter int CW    = $clog2(NPROC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] n_in,
    input  logic          admit,
    input  logic          leave,
    output logic [CW-1:0] cnt,
    output gate_e         gate
);
    logic [CW-1:0] lim_q;
    logic [CW-1:0] n_clamped;
    logic [CW-1:0] lim;
    logic [CW-1:0] cnt_up;
    logic [CW-1:0] cnt_dn;
    logic          idle;

    always_comb begin
        n_clamped = CW'(clamp_part(int'(n_in), NPROC));
        idle      = (gate == GATE_ENTRY) && (cnt == '0);
        lim       = idle ? n_clamped : lim_q;
        cnt_up    = cnt + CW'(1);
        cnt_dn    = cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            gate  <= GATE_ENTRY;
            lim_q <= CW'(1);
        end else begin
            if (idle)
                lim_q <= n_clamped;
            if (gate == GATE_ENTRY && admit) begin
                cnt <= cnt_up;
                if (cnt_up >= lim)
                    gate <= GATE_EXIT;
            end else if (gate == GATE_EXIT && leave) begin
                cnt <= cnt_dn;
                if (cnt_dn == '0)
                    gate <= GATE_ENTRY;
            end
        end
    end
endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
    import barrier_pkg::*;
#(
    parameter  int NPROC = 8,
    localparam int CW    = $clog2(NPROC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    part_n,
    input  logic [NPROC-1:0] arr_req,
    output logic [NPROC-1:0] go,
    output logic             arr_open,
    output logic             dep_open,
    output logic [CW-1:0]    cnt
);
    gate_e            gate;
    gate_view_t       gv;
    logic [NPROC-1:0] held;
    logic [NPROC-1:0] entry_cand;
    logic [NPROC-1:0] exit_cand;
    logic [NPROC-1:0] entry_grant;
    logic [NPROC-1:0] exit_grant;
    logic             entry_any;
    logic             exit_any;

    assign gv         = view_of(gate);
    assign entry_cand = arr_req & ~held & {NPROC{gv.entry_open}};
    assign exit_cand  = held & {NPROC{gv.exit_open}};

    barrier_pick #(.W(NPROC)) u_entry_pick (
        .cand  (entry_cand),
        .grant (entry_grant),
        .any   (entry_any)
    );

    barrier_pick #(.W(NPROC)) u_exit_pick (
        .cand  (exit_cand),
        .grant (exit_grant),
        .any   (exit_any)
    );

    barrier_slots #(.NPROC(NPROC)) u_slots (
        .clk   (clk),
        .rst   (rst),
        .set_v (entry_grant),
        .clr_v (exit_grant),
        .held  (held)
    );

    barrier_gate #(.NPROC(NPROC), .CW(CW)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .n_in  (part_n),
        .admit (entry_any),
        .leave (exit_any),
        .cnt   (cnt),
        .gate  (gate)
    );

    always_ff @(posedge clk) begin
        if (rst)
            go <= '0;
        else
            go <= exit_grant;
    end

    assign arr_open = gv.entry_open;
    assign dep_open = gv.exit_open;
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
    parameter  int NPROC = 8,
    localparam int CW    = $clog2(NPROC + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [NPROC-1:0] go,
    input logic             arr_open,
    input logic             dep_open,
    input logic [CW-1:0]    cnt
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && arr_open && !dep_open && go == '0)); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || ($past(cnt) == cnt + CW'(1))); // R2

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(NPROC)); // R2

    AST_GATES_EXCL: assert property (@(posedge clk) disable iff (rst)
        arr_open != dep_open); // R3

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go)); // R4

    AST_LAST_REOPENS: assert property (@(posedge clk) disable iff (rst)
        ($past(dep_open) && $past(cnt) == CW'(1) && (|go)) |-> (arr_open && !dep_open && cnt == '0)); // R5

    AST_GO_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
        (|go) |-> $past(dep_open)); // R6

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(dep_open) |-> (cnt <= $past(cnt))); // R7
endmodule

bind barrier_sync barrier_sync_chk #(.NPROC(NPROC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .arr_open (arr_open),
    .dep_open (dep_open),
    .cnt      (cnt)
);

// File: tb/tb_barrier_sync.sv
module tb_barrier_sync;
    localparam int NP = 8;
    localparam int CW = $clog2(NP + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] part_n = CW'(3);
    logic [NP-1:0] arr_req = '0;
    logic [NP-1:0] go;
    logic          arr_open;
    logic          dep_open;
    logic [CW-1:0] cnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    barrier_sync #(.NPROC(NP)) dut (
        .clk(clk), .rst(rst), .part_n(part_n), .arr_req(arr_req),
        .go(go), .arr_open(arr_open), .dep_open(dep_open), .cnt(cnt)
    );

    // Behavioural reference model
    int            m_cnt;
    bit            m_open;
    int            m_lim;
    bit            m_in [NP];
    logic [NP-1:0] m_go;

    function automatic int clampn(input int v);
        if (v < 1) return 1;
        if (v > NP) return NP;
        return v;
    endfunction

    always @(posedge clk) begin : model
        int lim;
        bit idle;
        bit took;
        if (rst) begin
            m_cnt = 0; m_open = 1; m_lim = 1; m_go = '0;
            for (int i = 0; i < NP; i++) m_in[i] = 0;
        end else begin
            m_go = '0;
            took = 0;
            idle = m_open && (m_cnt == 0);
            lim  = idle ? clampn(int'(part_n)) : m_lim;
            if (idle) m_lim = clampn(int'(part_n));
            if (m_open) begin
                for (int i = 0; i < NP; i++) begin
                    if (!took && arr_req[i] && !m_in[i]) begin
                        took = 1; m_in[i] = 1; m_cnt++;
                        if (m_cnt >= lim) m_open = 0;
                    end
                end
            end else begin
                for (int i = 0; i < NP; i++) begin
                    if (!took && m_in[i]) begin
                        took = 1; m_in[i] = 0; m_go[i] = 1'b1; m_cnt--;
                        if (m_cnt == 0) m_open = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one clock, compare every output against the model, then
    // let released processors drop their requests.
    task automatic step();
        @(negedge clk);
        chk(go == m_go, "R4 go", int'(go), int'(m_go));
        chk(int'(cnt) == m_cnt, "R2 cnt", int'(cnt), m_cnt);
        chk(arr_open == m_open, "R3 arr_open", int'(arr_open), int'(m_open));
        chk(dep_open == !m_open, "R5 dep_open", int'(dep_open), int'(!m_open));
        arr_req = arr_req & ~go;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin : stim
        logic [15:0] lfsr;
        repeat (3) step();
        chk(cnt == '0 && arr_open && !dep_open && go == '0, "R1 reset state",
            int'(cnt), 0);
        rst = 1'b0;
        step();
        chk(cnt == '0 && arr_open && !dep_open && go == '0, "R1 after reset",
            int'(cnt), 0);

        // Three simultaneous requests, limit 3
        part_n  = CW'(3);
        arr_req = 8'b0110_0010;
        step();
        chk(int'(cnt) == 1, "R2 one arrival per cycle", int'(cnt), 1);
        step();
        chk(go == '0 && !dep_open, "R6 no release before full", int'(go), 0);
        step();
        chk(dep_open && !arr_open, "R3 exit opens at limit", int'(dep_open), 1);
        step();
        chk(go == 8'h02, "R4 lowest released first", int'(go), 2);
        step();
        chk(go == 8'h20, "R4 second release", int'(go), 32);
        // Fast re-arrivals during the drain
        arr_req = arr_req | 8'b0000_0101;
        step();
        chk(go == 8'h40 && arr_open && !dep_open, "R5 last release reopens",
            int'(go), 64);
        chk(int'(cnt) == 0, "R7 held during drain", int'(cnt), 0);
        step();
        chk(int'(cnt) == 1, "R7 admitted after reopen", int'(cnt), 1);
        step();
        arr_req[7] = 1'b1;
        repeat (8) step();
        chk(arr_open && cnt == '0, "R5 idle after drain", int'(cnt), 0);

        // Limit change mid-episode is ignored
        part_n  = CW'(2);
        arr_req = 8'b0000_0011;
        step();
        part_n = CW'(5);
        step();
        chk(dep_open && int'(cnt) == 2, "R8 limit latched", int'(cnt), 2);
        repeat (4) step();

        // Clamped limits
        part_n     = CW'(0);
        arr_req[3] = 1'b1;
        step();
        chk(dep_open && int'(cnt) == 1, "R9 zero acts as one", int'(cnt), 1);
        repeat (3) step();
        part_n  = CW'(15);
        arr_req = '1;
        repeat (7) step();
        chk(!dep_open, "R9 large limit not full at 7", int'(dep_open), 0);
        step();
        chk(dep_open && int'(cnt) == 8, "R9 large limit acts as all", int'(cnt), 8);
        repeat (10) step();

        // Mixed traffic
        lfsr = 16'hACE1;
        for (int it = 0; it < 300; it++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (it % 7 == 0) part_n = CW'(lfsr[11:8] % 10);
            arr_req = arr_req | (lfsr[7:0] & lfsr[15:8]);
            step();
        end
        finish_run();
    end
endmodule